// File: doc/BRIEF.md
# Four-Bank Row-Cached DRAM

This block is a cycle-level, synthesizable model of a DRAM whose reads are never taken straight from the storage array. Each of four banks owns a one-row SRAM register and a latch holding the tag of the row last read into it. A read row strobe compares the incoming row with the latch of its bank. On a hit the row register already holds the data. On a miss the whole row is copied from the array into the register in a single cycle, and the latch takes the new tag. Column strobes then read words out of the register, one per cycle.

Writes never stall. Each write lands in a one-entry posting register and reaches the array on the following clock edge. If the written row is the one cached in its bank, the row register is updated in the same cycle, so the cache stays coherent. A reload that reads a row with a write still in the posting register merges that word in.

Refresh is driven by an internal row counter. It runs alongside cache reads. It gives way for one cycle to a miss reload that uses the array in the same bank.

The default geometry is deliberately small: 64 rows, 16 columns and 8-bit words. Every dimension is a parameter.

Top module: `rowcache_dram`

## Requirements
- R1: After reset, `hit_o`, `miss_o` and `rfsh_ack_o` are low, `dq_o` is zero and `bank_o` is zero. Every bank's tag latch is invalid, so the first read row strobe to each bank reports a miss.
- R2: The bank is `row_addr_i[4:3]` (parameter `BANK_LSB` = 3, two bits). The remaining four row bits form the tag. `bank_o` shows the bank of the most recent row strobe from the cycle after that strobe.
- R3: A read row strobe (`row_stb_i` = 1 with `we_i` = 0) whose tag equals the valid latch of its bank raises `hit_o` for exactly the next cycle, and the cached row is kept.
- R4: A read row strobe that does not hit raises `miss_o` for the next cycle. It loads the entire row into the bank's register and sets the latch, so that a column read in the very next cycle returns array data.
- R5: A column read (`col_stb_i` = 1, `we_i` = 0) issued in cycle n drives the word onto `dq_o` in cycle n+1 while `oe_i` is high. Column reads may follow each other on every cycle. `dq_o` is zero while `oe_i` is low.
- R6: The four banks are independent: a miss in one bank does not evict the row cached in another.
- R7: A write row strobe (`we_i` = 1) opens a row for writing without comparing, without pulsing `hit_o` or `miss_o`, and without changing any latch. Written words reach the array, and a miss reload issued in the cycle right after a write returns the new word.
- R8: A write to the row cached in its bank also updates that bank's row register, so a later hit read returns the new word.
- R9: Writes on consecutive cycles are accepted without stalls and reach the array in issue order. The last write to an address wins.
- R10: A refresh request pulses `rfsh_ack_o` in the next cycle, with `rfsh_row_o` showing the refreshed row. The counter starts at row 0 after reset and advances by one per refresh.
- R11: If the refresh row lies in the same bank as a miss reload in the same cycle, the refresh acknowledge is delayed by one cycle. A reload in another bank, or a hit in the same bank, does not delay it.
- R12: A column read in the same cycle as a refresh returns the correct cached word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb_i | input | 1 | Row strobe; takes priority over a column strobe in the same cycle |
| row_addr_i | input | ROW_W | Row address (bank bits plus tag bits) |
| col_stb_i | input | 1 | Column strobe |
| col_addr_i | input | COL_W | Column address within the open row |
| we_i | input | 1 | 1 = write, 0 = read, for both strobes |
| oe_i | input | 1 | Output enable for `dq_o` |
| wdata_i | input | DATA_W | Write data |
| refresh_i | input | 1 | Refresh request |
| hit_o | output | 1 | Row hit pulse |
| miss_o | output | 1 | Row miss pulse |
| bank_o | output | BANK_W | Bank of the last row strobe |
| dq_o | output | DATA_W | Read data |
| rfsh_ack_o | output | 1 | Refresh performed |
| rfsh_row_o | output | ROW_W | Row refreshed |

## Verification
A scripted access sequence across all four banks covers several patterns. Repeated columns in one row separate hits from misses. Alternating rows in one bank show eviction. Interleaving banks shows that bank tags do not interfere. The reads compare every word with a flat reference memory, and the observed hit and miss totals are matched against the sequence. Write-then-read patterns separate the three paths a written word can take: the row-register update on a hit, the posting-register merge on an immediate reload, and the in-order drain of back-to-back writes. Refresh is paired with a same-bank miss, another-bank miss, a same-bank hit and a column read, which tells the deferral case apart from the cases that must not defer.

// File: rtl/rowcache_dram.sv
module rowcache_dram #(
  parameter int DATA_W   = 8,
  parameter int ROW_W    = 6,
  parameter int COL_W    = 4,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_i,
  input  logic [ROW_W-1:0]  row_addr_i,
  input  logic              col_stb_i,
  input  logic [COL_W-1:0]  col_addr_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              refresh_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              rfsh_ack_o,
  output logic [ROW_W-1:0]  rfsh_row_o
);
  localparam int NBANK = 1 << BANK_W;
  localparam int NCOL  = 1 << COL_W;
  localparam int NROW  = 1 << ROW_W;
  localparam int TAG_W = ROW_W - BANK_W;
  localparam int AW    = ROW_W + COL_W;

  function automatic logic [TAG_W-1:0] tag_of(input logic [ROW_W-1:0] r);
    logic [TAG_W-1:0] t;
    int j;
    t = '0;
    j = 0;
    for (int i = 0; i < ROW_W; i++) begin
      if (i < BANK_LSB || i >= BANK_LSB + BANK_W) begin
        t[j] = r[i];
        j++;
      end
    end
    return t;
  endfunction

  logic [DATA_W-1:0] mem    [NROW*NCOL];
  logic [DATA_W-1:0] rowreg [NBANK*NCOL];
  logic [TAG_W-1:0]  tag_q  [NBANK];
  logic [NBANK-1:0]  tag_vld;

  logic [ROW_W-1:0]  open_row;
  logic              post_vld;
  logic [AW-1:0]     post_addr;
  logic [DATA_W-1:0] post_data;
  logic [ROW_W-1:0]  rf_cnt;
  logic              rf_pend;
  logic [DATA_W-1:0] rdata;

  wire [BANK_W-1:0] in_bank = row_addr_i[BANK_LSB +: BANK_W];
  wire [TAG_W-1:0]  in_tag  = tag_of(row_addr_i);
  wire              in_hit  = tag_vld[in_bank] && (tag_q[in_bank] == in_tag);
  wire              rd_row  = row_stb_i && !we_i;
  wire              reload  = rd_row && !in_hit;

  wire [BANK_W-1:0] ob        = open_row[BANK_LSB +: BANK_W];
  wire              col_go    = col_stb_i && !row_stb_i;
  wire              wr_go     = col_go && we_i;
  wire              rd_go     = col_go && !we_i;
  wire              wr_cached = tag_vld[ob] && (tag_q[ob] == tag_of(open_row));

  wire rf_req   = refresh_i || rf_pend;
  wire rf_block = reload && (rf_cnt[BANK_LSB +: BANK_W] == in_bank);

  assign dq_o = oe_i ? rdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_vld    <= '0;
      open_row   <= '0;
      bank_o     <= '0;
      hit_o      <= 1'b0;
      miss_o     <= 1'b0;
      post_vld   <= 1'b0;
      post_addr  <= '0;
      post_data  <= '0;
      rf_cnt     <= '0;
      rf_pend    <= 1'b0;
      rfsh_ack_o <= 1'b0;
      rfsh_row_o <= '0;
      rdata      <= '0;
    end else begin
      hit_o  <= rd_row && in_hit;
      miss_o <= reload;
      if (row_stb_i) begin
        open_row <= row_addr_i;
        bank_o   <= in_bank;
      end
      if (reload) tag_vld[in_bank] <= 1'b1;
      post_vld <= wr_go;
      if (wr_go) begin
        post_addr <= {open_row, col_addr_i};
        post_data <= wdata_i;
      end
      if (rd_go) rdata <= rowreg[{ob, col_addr_i}];
      rfsh_ack_o <= 1'b0;
      if (rf_req) begin
        if (rf_block) begin
          rf_pend <= 1'b1;
        end else begin
          rf_pend    <= 1'b0;
          rfsh_ack_o <= 1'b1;
          rfsh_row_o <= rf_cnt;
          rf_cnt     <= rf_cnt + ROW_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (reload) tag_q[in_bank] <= in_tag;
  end

  always_ff @(posedge clk) begin
    if (post_vld) mem[post_addr] <= post_data;
  end

  always_ff @(posedge clk) begin
    if (reload) begin
      for (int c = 0; c < NCOL; c++) begin
        rowreg[{in_bank, COL_W'(c)}] <=
          (post_vld && post_addr == {row_addr_i, COL_W'(c)}) ? post_data
                                                             : mem[{row_addr_i, COL_W'(c)}];
      end
    end else if (wr_go && wr_cached) begin
      rowreg[{ob, col_addr_i}] <= wdata_i;
    end
  end

  a_r1_first_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rd_row && !tag_vld[in_bank] |=> miss_o);

  a_r3_hit_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
    rd_row && in_hit |=> hit_o && !miss_o && tag_q[$past(in_bank)] == $past(in_tag));

  a_r4_miss_fills_latch: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> tag_vld[$past(in_bank)] && tag_q[$past(in_bank)] == $past(in_tag));

  a_r9_post_lands: assert property (@(posedge clk) disable iff (!rst_n)
    post_vld |=> mem[$past(post_addr)] == $past(post_data));

  a_r8_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && wr_cached |=> rowreg[$past({ob, col_addr_i})] == $past(wdata_i));

  a_r10_refresh_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req && !rf_block |=> rfsh_ack_o && rfsh_row_o == $past(rf_cnt));

  a_r11_refresh_defer: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req && rf_block |=> !rfsh_ack_o && rf_pend);
endmodule

// File: tb/rowcache_dram_bench.sv
module rowcache_dram_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       row_stb_i = 1'b0;
  logic [5:0] row_addr_i = '0;
  logic       col_stb_i = 1'b0;
  logic [3:0] col_addr_i = '0;
  logic       we_i = 1'b0;
  logic       oe_i = 1'b1;
  logic [7:0] wdata_i = '0;
  logic       refresh_i = 1'b0;
  logic       hit_o, miss_o, rfsh_ack_o;
  logic [1:0] bank_o;
  logic [7:0] dq_o;
  logic [5:0] rfsh_row_o;

  int total = 0;
  int bad = 0;
  logic [7:0] refm [1024];

  always #5 clk = ~clk;

  rowcache_dram u_rowcache_dram (
    .clk(clk), .rst_n(rst_n), .row_stb_i(row_stb_i), .row_addr_i(row_addr_i),
    .col_stb_i(col_stb_i), .col_addr_i(col_addr_i), .we_i(we_i), .oe_i(oe_i),
    .wdata_i(wdata_i), .refresh_i(refresh_i), .hit_o(hit_o), .miss_o(miss_o),
    .bank_o(bank_o), .dq_o(dq_o), .rfsh_ack_o(rfsh_ack_o), .rfsh_row_o(rfsh_row_o));

  // {row, col, expected hit}
  localparam logic [10:0] VEC [14] = '{
    {6'h00, 4'd3,  1'b0}, {6'h00, 4'd7,  1'b1}, {6'h08, 4'd1,  1'b0},
    {6'h00, 4'd15, 1'b1}, {6'h20, 4'd2,  1'b0}, {6'h08, 4'd0,  1'b1},
    {6'h00, 4'd3,  1'b0}, {6'h10, 4'd9,  1'b0}, {6'h18, 4'd4,  1'b0},
    {6'h10, 4'd5,  1'b1}, {6'h01, 4'd0,  1'b0}, {6'h18, 4'd15, 1'b1},
    {6'h3F, 4'd15, 1'b0}, {6'h18, 4'd0,  1'b0}};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_row(input logic [5:0] r, input logic w);
    row_stb_i = 1'b1; row_addr_i = r; we_i = w;
    @(negedge clk);
    row_stb_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] c);
    col_stb_i = 1'b1; col_addr_i = c; we_i = 1'b0;
    @(negedge clk);
    col_stb_i = 1'b0;
  endtask

  task automatic wr(input logic [5:0] r, input logic [3:0] c, input logic [7:0] d);
    col_stb_i = 1'b1; col_addr_i = c; we_i = 1'b1; wdata_i = d;
    refm[{r, c}] = d;
    @(negedge clk);
    col_stb_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int hits;
    int misses;
    int exp_hits;
    @(negedge clk);
    do_reset();
    // R10 R11: refresh with counter starting at 0 (rows 0..7 are bank 0)
    refresh_i = 1'b1;
    @(negedge clk);
    refresh_i = 1'b0;
    check("R10 ack", rfsh_ack_o, 1);
    check("R10 row", rfsh_row_o, 0);
    @(negedge clk);
    check("R10 pulse", rfsh_ack_o, 0);
    refresh_i = 1'b1;
    open_row(6'h00, 1'b0);
    refresh_i = 1'b0;
    check("R11 same bank deferred", rfsh_ack_o, 0);
    check("R1 first read misses", miss_o, 1);
    @(negedge clk);
    check("R11 deferred ack", rfsh_ack_o, 1);
    check("R11 deferred row", rfsh_row_o, 1);
    refresh_i = 1'b1;
    open_row(6'h08, 1'b0);
    refresh_i = 1'b0;
    check("R11 other bank not deferred", rfsh_ack_o, 1);
    check("R11 other bank row", rfsh_row_o, 2);

    do_reset();
    check("R1 hit", hit_o, 0);
    check("R1 miss", miss_o, 0);
    check("R1 ack", rfsh_ack_o, 0);
    check("R1 dq", dq_o, 0);
    check("R1 bank", bank_o, 0);

    for (int r = 0; r < 64; r++) begin
      open_row(6'(r), 1'b1);
      if (r == 0) begin
        check("R7 write strobe no hit", hit_o, 0);
        check("R7 write strobe no miss", miss_o, 0);
      end
      for (int c = 0; c < 16; c++) wr(6'(r), 4'(c), 8'(r * 37 + c * 5 + 1));
    end
    @(negedge clk);

    hits = 0; misses = 0; exp_hits = 0;
    for (int i = 0; i < 14; i++) begin
      logic [5:0] r;
      logic [3:0] c;
      logic       h;
      {r, c, h} = VEC[i];
      exp_hits += int'(h);
      open_row(r, 1'b0);
      hits += int'(hit_o);
      misses += int'(miss_o);
      check(h ? "R3 R6 hit" : "R1 R4 R6 miss", {hit_o, miss_o}, {h, !h});
      check("R2 bank", bank_o, r[4:3]);
      rd(c);
      check("R4 R5 data", dq_o, refm[{r, c}]);
    end
    check("R3 hit count", hits, exp_hits);
    check("R4 miss count", misses, 14 - exp_hits);

    // R5 back-to-back reads on cached row 0x18, then oe
    col_stb_i = 1'b1; col_addr_i = 4'd0;
    @(negedge clk);
    for (int k = 1; k < 4; k++) begin
      check("R5 back-to-back", dq_o, refm[{6'h18, 4'(k - 1)}]);
      col_addr_i = 4'(k);
      @(negedge clk);
    end
    col_stb_i = 1'b0;
    check("R5 last burst word", dq_o, refm[{6'h18, 4'd3}]);
    oe_i = 1'b0;
    #1;
    check("R5 oe low", dq_o, 0);
    oe_i = 1'b1;

    // R12: read during refresh (counter 0 after reset)
    refresh_i = 1'b1;
    rd(4'd7);
    refresh_i = 1'b0;
    check("R12 data during refresh", dq_o, refm[{6'h18, 4'd7}]);
    check("R12 refresh ack", rfsh_ack_o, 1);
    check("R12 refresh row", rfsh_row_o, 0);

    // R11: same-bank hit does not defer (counter 1 -> bank 0, row 0x01 cached)
    refresh_i = 1'b1;
    open_row(6'h01, 1'b0);
    refresh_i = 1'b0;
    check("R11 hit same bank", hit_o, 1);
    check("R11 hit not deferred", rfsh_ack_o, 1);
    check("R11 hit row", rfsh_row_o, 1);

    // R8 coherence
    open_row(6'h18, 1'b1);
    check("R7 write strobe no compare", {hit_o, miss_o}, 0);
    wr(6'h18, 4'd2, 8'hA5);
    open_row(6'h18, 1'b0);
    check("R8 still hit", hit_o, 1);
    rd(4'd2);
    check("R8 coherent data", dq_o, 8'hA5);

    // R7 reload right after a posted write
    open_row(6'h02, 1'b1);
    wr(6'h02, 4'd6, 8'h5A);
    open_row(6'h02, 1'b0);
    check("R7 reload miss", miss_o, 1);
    rd(4'd6);
    check("R7 merged write", dq_o, 8'h5A);

    // R9 back-to-back writes
    open_row(6'h03, 1'b1);
    wr(6'h03, 4'd1, 8'h11);
    wr(6'h03, 4'd1, 8'h22);
    wr(6'h03, 4'd2, 8'h33);
    open_row(6'h03, 1'b0);
    check("R9 miss", miss_o, 1);
    rd(4'd1);
    check("R9 last wins", dq_o, 8'h22);
    rd(4'd2);
    check("R9 second write", dq_o, 8'h33);

    finish_run();
  end
endmodule